// File: doc/BRIEF.md
# Halt and Wake-up Controller

This block sits beside a small processor core and owns the power-down halt state. A halt instruction from the core parks the block in the halted state, sets the power-down flag, clears the time-out flag and drops the oscillator enable. While halted, the block watches four wake-up sources: an external reset request, the interrupt request lines, falling edges on an 8-bit port whose bits are individually enabled for wake-up, and the watchdog overflow.

When a wake-up source fires, the block raises the oscillator enable again. It holds the core for a fixed settling window and then issues one single-cycle command. The command is one of four: continue at the next instruction, take the interrupt vector, warm-reset the program counter and stack pointer, or run a full device initialization. The interrupt controller and the stack live outside the block. The per-source interrupt enables and the stack-full condition arrive as inputs and are used only to choose the command after an interrupt wake-up.

Top module: `pwrdn_wake_ctrl`

## Requirements
- R1: After the power-up reset `rst_ni`, `pd_o` and `to_o` are 0, `osc_en_o` is 1, `core_hold_o` is 0 and no command pulse is high.
- R2: A `halt_i` pulse while running makes `pd_o`=1, `to_o`=0, `osc_en_o`=0 and `core_hold_o`=1 from the next cycle on.
- R3: While running, `clrwdt_i` clears both `pd_o` and `to_o`, and `wdt_ovf_i` sets `to_o` without touching `pd_o`. While halted or settling, `halt_i` and `clrwdt_i` have no effect.
- R4: While halted, a 1-to-0 change on `port_i[i]` with `port_wake_en_i[i]`=1 wakes the block and leads to the continue command. Rising changes and changes on bits whose enable is 0 do not wake it.
- R5: While halted, a raised request on an interrupt source that was not already requesting at halt entry wakes the block. The command is the vector command if some such source has its enable set and `stack_full_i`=0. Otherwise it is the continue command.
- R6: An interrupt source whose request was high in the cycle `halt_i` was accepted cannot wake the block during that halt.
- R7: A watchdog overflow while halted wakes the block, sets `to_o` at the wake-up, and leads to the warm-reset command.
- R8: An external reset request while halted wakes the block and leads to the full-initialization command, with `pd_o` left at 1 and `to_o` left at 0.
- R9: When several sources fire in the same halted cycle, the command follows the fixed priority external reset > watchdog > interrupt > port. `to_o` is set only when the warm-reset command is chosen.
- R10: After the wake-up clock edge, `osc_en_o` is 1 and `core_hold_o` stays 1 for exactly SETTLE_CYCLES (default 1024) cycles. The command pulse is high in the first cycle with `core_hold_o`=0 and lasts one cycle. Encoding of the pulses as {full,warm,vector,resume}: continue 0001, vector 0010, warm 0100, full 1000.
- R11: During the settling window, an external reset request restarts the full SETTLE_CYCLES count from its clock edge and changes the command to full initialization. Watchdog, interrupt and port events during the window are ignored.
- R12: At most one command pulse is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Power-up reset, active low, asynchronous |
| halt_i | input | 1 | Halt instruction executed (one-cycle pulse) |
| clrwdt_i | input | 1 | Clear-watchdog instruction executed |
| wdt_ovf_i | input | 1 | Watchdog overflow |
| ext_rst_i | input | 1 | External reset request |
| irq_req_i | input | N_IRQ | Interrupt request flags |
| irq_en_i | input | N_IRQ | Per-source interrupt enables |
| stack_full_i | input | 1 | Return stack has no free entry |
| port_i | input | PORT_W | Port pin levels |
| port_wake_en_i | input | PORT_W | Per-bit wake-up enable for the port |
| osc_en_o | output | 1 | System oscillator enable (0 while halted) |
| core_hold_o | output | 1 | Core stalled (halted or settling) |
| pd_o | output | 1 | Power-down flag |
| to_o | output | 1 | Time-out flag |
| resume_o | output | 1 | Continue at next instruction (pulse) |
| vector_o | output | 1 | Take the interrupt vector (pulse) |
| warm_rst_o | output | 1 | Reset program counter and stack pointer (pulse) |
| full_init_o | output | 1 | Full device initialization (pulse) |

## Verification
The bench sweeps every port bit through its own masked falling-edge wake-up. It checks that rising edges and disabled bits leave the block halted; a design that compared unmasked values or detected both edges would wake early. It runs all combinations of interrupt source, enable and stack-full, and checks a request pending at halt entry. A design that ignored the pending snapshot would wake at once, and one that swapped the stack-full sense would vector into a full stack. Simultaneous sources check the priority and the rule that `to_o` is set only by a winning watchdog. Late events inside the settling window check the restart rule: an off-by-one counter or a restart on any source would move or change the command pulse.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

   typedef enum logic [1:0] {
      ST_RUN    = 2'd0,
      ST_HALT   = 2'd1,
      ST_SETTLE = 2'd2
   } pwr_state_e;

   // Bit position of each command in the pulse vector
   typedef enum logic [1:0] {
      ACT_RESUME = 2'd0,
      ACT_VECTOR = 2'd1,
      ACT_WARM   = 2'd2,
      ACT_FULL   = 2'd3
   } wake_act_e;

   localparam int unsigned N_ACT = 4;

endpackage

// File: rtl/pwrdn_port_edge.sv
module pwrdn_port_edge #(
   parameter int unsigned PORT_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [PORT_W-1:0] port_i,
   input  logic [PORT_W-1:0] en_i,
   output logic [PORT_W-1:0] fall_o
);

   logic [PORT_W-1:0] prev_q;

   for (genvar b = 0; b < PORT_W; b++) begin : g_bit
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) prev_q[b] <= 1'b0;
         else         prev_q[b] <= port_i[b] & en_i[b];
      end

      assign fall_o[b] = prev_q[b] & ~port_i[b] & en_i[b];

      AST_FALL_IS_REAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
         fall_o[b] |-> ($past(port_i[b]) && !port_i[b])); // R4
   end

endmodule

// File: rtl/pwrdn_wake_arb.sv
module pwrdn_wake_arb
   import pwrdn_pkg::*;
#(
   parameter int unsigned N_IRQ  = 2,
   parameter int unsigned PORT_W = 8
) (
   input  logic              ext_i,
   input  logic              wdt_i,
   input  logic [N_IRQ-1:0]  irq_req_i,
   input  logic [N_IRQ-1:0]  irq_en_i,
   input  logic [N_IRQ-1:0]  irq_blocked_i,
   input  logic              stack_full_i,
   input  logic [PORT_W-1:0] port_fall_i,
   output logic              wake_o,
   output wake_act_e         act_o
);

   logic [N_IRQ-1:0] irq_live;
   logic             irq_any;
   logic             irq_vec;

   assign irq_live = irq_req_i & ~irq_blocked_i;
   assign irq_any  = |irq_live;
   assign irq_vec  = (|(irq_live & irq_en_i)) & ~stack_full_i;
   assign wake_o   = ext_i | wdt_i | irq_any | (|port_fall_i);

   always_comb begin
      if (ext_i)        act_o = ACT_FULL;
      else if (wdt_i)   act_o = ACT_WARM;
      else if (irq_vec) act_o = ACT_VECTOR;
      else              act_o = ACT_RESUME;
   end

endmodule

// File: rtl/pwrdn_settle_timer.sv
module pwrdn_settle_timer #(
   parameter int unsigned CYCLES = 1024
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic start_i,
   output logic busy_o,
   output logic done_o
);

   localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q  <= '0;
         busy_o <= 1'b0;
      end else if (start_i) begin
         cnt_q  <= '0;
         busy_o <= 1'b1;
      end else if (busy_o) begin
         if (cnt_q == LAST) busy_o <= 1'b0;
         else               cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = busy_o & (cnt_q == LAST);

   AST_SETTLE_FULL_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(busy_o) |-> ($past(cnt_q) == LAST)); // R10
   AST_RESTART_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_i |=> (busy_o && cnt_q == '0)); // R11

endmodule

// File: rtl/pwrdn_wake_ctrl.sv
module pwrdn_wake_ctrl
   import pwrdn_pkg::*;
#(
   parameter int unsigned PORT_W        = 8,
   parameter int unsigned N_IRQ         = 2,
   parameter int unsigned SETTLE_CYCLES = 1024
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              halt_i,
   input  logic              clrwdt_i,
   input  logic              wdt_ovf_i,
   input  logic              ext_rst_i,
   input  logic [N_IRQ-1:0]  irq_req_i,
   input  logic [N_IRQ-1:0]  irq_en_i,
   input  logic              stack_full_i,
   input  logic [PORT_W-1:0] port_i,
   input  logic [PORT_W-1:0] port_wake_en_i,
   output logic              osc_en_o,
   output logic              core_hold_o,
   output logic              pd_o,
   output logic              to_o,
   output logic              resume_o,
   output logic              vector_o,
   output logic              warm_rst_o,
   output logic              full_init_o
);

   if (PORT_W < 1 || N_IRQ < 1 || SETTLE_CYCLES < 2) begin : g_param_check
      $error("pwrdn_wake_ctrl: PORT_W, N_IRQ must be >= 1 and SETTLE_CYCLES >= 2");
   end

   pwr_state_e        state_q;
   wake_act_e         act_q;
   wake_act_e         arb_act;
   logic [N_IRQ-1:0]  blocked_q;
   logic [N_ACT-1:0]  pulse_q;
   logic [PORT_W-1:0] port_fall;
   logic              arb_wake;
   logic              in_halt;
   logic              in_settle;
   logic              wake_now;
   logic              tmr_start;
   logic              tmr_busy;
   logic              tmr_done;

   assign in_halt   = (state_q == ST_HALT);
   assign in_settle = (state_q == ST_SETTLE);
   assign wake_now  = in_halt & arb_wake;
   assign tmr_start = wake_now | (in_settle & ext_rst_i);

   pwrdn_port_edge #(.PORT_W(PORT_W)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .port_i (port_i),
      .en_i   (port_wake_en_i),
      .fall_o (port_fall)
   );

   pwrdn_wake_arb #(.N_IRQ(N_IRQ), .PORT_W(PORT_W)) u_arb (
      .ext_i         (ext_rst_i),
      .wdt_i         (wdt_ovf_i),
      .irq_req_i     (irq_req_i),
      .irq_en_i      (irq_en_i),
      .irq_blocked_i (blocked_q),
      .stack_full_i  (stack_full_i),
      .port_fall_i   (port_fall),
      .wake_o        (arb_wake),
      .act_o         (arb_act)
   );

   pwrdn_settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .start_i (tmr_start),
      .busy_o  (tmr_busy),
      .done_o  (tmr_done)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q   <= ST_RUN;
         act_q     <= ACT_RESUME;
         blocked_q <= '0;
         pulse_q   <= '0;
         pd_o      <= 1'b0;
         to_o      <= 1'b0;
      end else begin
         pulse_q <= '0;
         unique case (state_q)
            ST_RUN: begin
               if (halt_i) begin
                  state_q   <= ST_HALT;
                  pd_o      <= 1'b1;
                  to_o      <= 1'b0;
                  blocked_q <= irq_req_i;
               end else begin
                  if (clrwdt_i) begin
                     pd_o <= 1'b0;
                     to_o <= 1'b0;
                  end
                  if (wdt_ovf_i) to_o <= 1'b1;
               end
            end
            ST_HALT: begin
               if (arb_wake) begin
                  state_q <= ST_SETTLE;
                  act_q   <= arb_act;
                  if (arb_act == ACT_WARM) to_o <= 1'b1;
               end
            end
            ST_SETTLE: begin
               if (ext_rst_i) begin
                  act_q <= ACT_FULL;
               end else if (tmr_done) begin
                  state_q <= ST_RUN;
                  pulse_q <= N_ACT'(1) << act_q;
               end
            end
            default: state_q <= ST_RUN;
         endcase
      end
   end

   assign osc_en_o    = ~in_halt;
   assign core_hold_o = (state_q != ST_RUN);
   assign resume_o    = pulse_q[ACT_RESUME];
   assign vector_o    = pulse_q[ACT_VECTOR];
   assign warm_rst_o  = pulse_q[ACT_WARM];
   assign full_init_o = pulse_q[ACT_FULL];

   AST_HALT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && halt_i) |=> (pd_o && !to_o && !osc_en_o && core_hold_o)); // R2
   AST_CLRWDT_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (state_q == ST_RUN && !halt_i && clrwdt_i && !wdt_ovf_i) |=> (!pd_o && !to_o)); // R3
   AST_PULSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(pulse_q)); // R12
   AST_PULSE_AFTER_SETTLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|pulse_q) |-> ($past(tmr_busy) && !core_hold_o)); // R10
   AST_WARM_HAS_TO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      warm_rst_o |-> to_o); // R7
   AST_PD_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      core_hold_o |-> pd_o); // R8

endmodule

// File: tb/pwrdn_wake_ctrl_bench.sv
module pwrdn_wake_ctrl_bench;

   localparam int PW  = 8;
   localparam int NI  = 2;
   localparam int SET = 1024;
   localparam logic [3:0] C_RES = 4'b0001, C_VEC = 4'b0010, C_WRM = 4'b0100, C_FUL = 4'b1000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          halt = 1'b0, clrwdt = 1'b0, wdt = 1'b0, ext = 1'b0, sfull = 1'b0;
   logic [NI-1:0] irq = '0, ien = '0;
   logic [PW-1:0] port = '1, pmask = '0;
   logic          osc_en, hold, pd, to, res, vec, wrm, ful;
   int            n_chk = 0, n_fail = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;

   pwrdn_wake_ctrl #(.PORT_W(PW), .N_IRQ(NI), .SETTLE_CYCLES(SET)) u_pwrdn_wake_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .clrwdt_i(clrwdt), .wdt_ovf_i(wdt),
      .ext_rst_i(ext), .irq_req_i(irq), .irq_en_i(ien), .stack_full_i(sfull),
      .port_i(port), .port_wake_en_i(pmask), .osc_en_o(osc_en), .core_hold_o(hold),
      .pd_o(pd), .to_o(to), .resume_o(res), .vector_o(vec), .warm_rst_o(wrm),
      .full_init_o(ful)
   );

   function automatic logic [3:0] cmds();
      return {ful, wrm, vec, res};
   endfunction

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic clear_wake();
      ext = 1'b0; wdt = 1'b0; irq = '0; port = '1;
   endtask

   task automatic go_halt();
      halt = 1'b1;
      @(negedge clk);
      halt = 1'b0;
      chk("R2 halt entry {pd,to,osc,hold}", {4'b0, pd, to, osc_en, hold}, 8'b0000_1001);
   endtask

   // Caller has applied the wake stimulus at the current negedge
   task automatic settle(input logic [3:0] exp, input string req);
      int bad = 0;
      @(negedge clk);
      clear_wake();
      chk({req, " R10 osc back on"}, {7'b0, osc_en}, 8'd1);
      for (int k = 0; k < SET - 1; k++) begin
         if (!hold || cmds() != 4'b0) bad++;
         @(negedge clk);
      end
      if (!hold || cmds() != 4'b0) bad++;
      chk({req, " R10 held silent through settle"}, 8'(bad), 8'd0);
      @(negedge clk);
      chk({req, " command pulse"}, {3'b0, hold, cmds()}, {4'b0, exp});
      @(negedge clk);
      chk({req, " R10 pulse one cycle"}, {3'b0, hold, cmds()}, 8'd0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset {pd,to,osc,hold,cmds}", {pd, to, osc_en, hold, cmds()}, 8'b0010_0000);

      // R4: every port bit alone
      for (int b = 0; b < PW; b++) begin
         pmask = PW'(1) << b;
         go_halt();
         port[b] = 1'b0;
         settle(C_RES, "R4 port bit fall");
      end

      // R4: disabled bit and rising edge do not wake
      pmask = 8'h0F;
      port[0] = 1'b0;
      @(negedge clk);
      go_halt();
      port[7] = 1'b0;
      port[0] = 1'b1;
      repeat (5) @(negedge clk);
      chk("R4 masked/rising ignored {osc,hold}", {6'b0, osc_en, hold}, 8'b01);
      port = '1;
      @(negedge clk);
      port[2] = 1'b0;
      settle(C_RES, "R4 enabled bit after ignored ones");

      // R5: source x enable x stack-full sweep
      pmask = '0;
      for (int s = 0; s < NI; s++)
         for (int e = 0; e < 2; e++)
            for (int f = 0; f < 2; f++) begin
               go_halt();
               irq[s] = 1'b1; ien = '0; ien[s] = e[0]; sfull = f[0];
               settle((e == 1 && f == 0) ? C_VEC : C_RES, "R5 irq wake");
            end
      sfull = 1'b0;

      // R6: pending request at halt entry
      irq[0] = 1'b1; ien = '1;
      @(negedge clk);
      go_halt();
      repeat (6) @(negedge clk);
      chk("R6 pending irq no wake {osc,hold}", {6'b0, osc_en, hold}, 8'b01);
      irq[1] = 1'b1;
      settle(C_VEC, "R6 other source still wakes");

      // R7 and R3
      go_halt();
      wdt = 1'b1;
      settle(C_WRM, "R7 watchdog wake");
      chk("R7 flags after warm {pd,to}", {6'b0, pd, to}, 8'b11);
      clrwdt = 1'b1;
      @(negedge clk);
      clrwdt = 1'b0;
      chk("R3 clrwdt clears {pd,to}", {6'b0, pd, to}, 8'b00);
      wdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0;
      chk("R3 run overflow sets to only {pd,to}", {6'b0, pd, to}, 8'b01);
      clrwdt = 1'b1;
      @(negedge clk);
      clrwdt = 1'b0;

      // R8
      go_halt();
      ext = 1'b1;
      settle(C_FUL, "R8 external reset wake");
      chk("R8 flags kept {pd,to}", {6'b0, pd, to}, 8'b10);

      // R9 priority
      pmask = '1; ien = '1;
      go_halt();
      ext = 1'b1; wdt = 1'b1; irq = '1; port = '0;
      settle(C_FUL, "R9 ext beats all");
      chk("R9 to stays clear when ext wins", {7'b0, to}, 8'd0);
      go_halt();
      wdt = 1'b1; irq = '1; port = '0;
      settle(C_WRM, "R9 wdt beats irq and port");
      go_halt();
      irq = 2'b10; port = '0;
      settle(C_VEC, "R9 irq beats port");

      // R11: ignored events and halt/clrwdt in settle, then ext restart
      go_halt();
      port[3] = 1'b0;
      @(negedge clk);
      clear_wake();
      repeat (99) @(negedge clk);
      wdt = 1'b1; irq = '1; halt = 1'b1; clrwdt = 1'b1;
      @(negedge clk);
      wdt = 1'b0; irq = '0; halt = 1'b0; clrwdt = 1'b0;
      repeat (SET - 101) @(negedge clk);
      chk("R11 still held before end", {7'b0, hold}, 8'd1);
      @(negedge clk);
      chk("R11 wdt in settle ignored", {3'b0, hold, cmds()}, {4'b0, C_RES});
      chk("R3 clrwdt in settle ignored {pd,to}", {6'b0, pd, to}, 8'b10);
      @(negedge clk);
      chk("R3 halt in settle ignored", {6'b0, osc_en, hold}, 8'b10);

      go_halt();
      port[5] = 1'b0;
      @(negedge clk);
      clear_wake();
      repeat (299) @(negedge clk);
      ext = 1'b1;
      settle(C_FUL, "R11 ext restart in settle");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule